// File: doc/BRIEF.md
# Grouped Interrupt Priority Controller

This block gathers interrupt request lines from peripherals and pins into groups of four factors and drives the CPU with one non-maskable request line and seven level request lines. Every factor has its own request latch, set by a rising edge on its input, and its own enable bit. Priority is held per group, not per factor. Each maskable group has a 3-bit priority level from 0 to 6, and level 0 is the most urgent. Group 0 is fixed as the non-maskable group. It drives the non-maskable output only. It has no level setting. Its enables cannot be changed. Its fourth factor is reserved.

Software uses a small word-wide register port. The address is `{group, sel}`. `sel` 0 selects the group level, read and write, in data bits [2:0]. `sel` 1 selects the factor enables, read and write, in bits [3:0]. `sel` 2 selects the pending flags in bits [3:0]; these read back, and writing 1 to a bit clears it. `sel` 3 selects the identification word, which is read only. It has a valid flag in bit 15, the winning group number from bit 8 upward, and that group's pending enabled factor mask in bits [3:0]. Reads are combinational. Writes take effect at the next rising clock edge. Addresses whose group number is beyond the last group read zero and ignore writes.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset:
  - all pending flags are 0;
  - maskable enables are 0 and maskable levels read 6;
  - group 0 enables read 4'b0111;
  - `nmi_o` and `lvl_req_o` are low;
  - the identification word reads 0.
- R2: A 0-to-1 change on a request input sets that factor's pending flag at the clock edge that samples the 1. A request held high does not set the flag again after it is cleared.
- R3: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A rising edge in the same cycle as a clear leaves the flag set.
- R4: `lvl_req_o[L]` is high exactly when some group numbered 1 or above, with level L, has a factor that is both pending and enabled.
- R5: A disabled factor still records pending, and the flag can be read. It raises no output, and the identification word ignores it.
- R6: Group 0 pending enabled factors drive `nmi_o` and never any `lvl_req_o` bit. The group 0 level reads 0, and writes to it are ignored.
- R7: Writes to the group 0 enable register are ignored. It always reads 4'b0111.
- R8: Group 0 factor 3 is reserved. Its pending bit reads 0 even after a rising edge on its input.
- R9: A level write of value 7 is ignored, and the previous level is kept.
- R10: The identification word names the highest-priority group that has a pending enabled factor. Group 0 ranks first, then lower level numbers. Ties go to the lower group number. With no such group the word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 76 | Request inputs, factor f of group g at bit 4*g+f |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register address {group[4:0], sel[1:0]} |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| nmi_o | output | 1 | Non-maskable request to the CPU |
| lvl_req_o | output | 7 | Level request lines, bit L for level L |

## Verification
The edge-to-pending assertions assume that request inputs are synchronous to `clk_i` and stay stable around each edge. The bench changes requests and bus signals only on falling edges. The identification and level-line assertions assume that software writes only levels 0 to 6 when it means a change. The bench writes 7 once, deliberately, and checks that the write is ignored. All reads are made while requests and the write strobe are idle, so the registers cannot change while a read is in progress.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int FACT_N = 4;
  localparam int LVL_N  = 7;
  localparam int LVL_W  = 3;
  localparam int DATA_W = 16;
  localparam logic [LVL_W-1:0]  LVL_MAX  = LVL_W'(LVL_N - 1);
  localparam logic [FACT_N-1:0] NMI_LIVE = 4'b0111;

  typedef enum logic [1:0] {
    SEL_LVL  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PEND = 2'd2,
    SEL_ID   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_grp_bank.sv
module irq_grp_bank
  import irq_grp_pkg::*;
#(
  parameter bit IS_NMI = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FACT_N-1:0] req_i,
  input  logic              lvl_we_i,
  input  logic              en_we_i,
  input  logic              clr_we_i,
  input  logic [FACT_N-1:0] wdata_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [FACT_N-1:0] en_o,
  output logic [FACT_N-1:0] pend_o,
  output logic [FACT_N-1:0] hit_o
);
  localparam logic [FACT_N-1:0] LIVE = IS_NMI ? NMI_LIVE : {FACT_N{1'b1}};

  logic [FACT_N-1:0] req_q, pend_q, rise, clr_mask;

  assign rise     = req_i & ~req_q & LIVE;
  assign clr_mask = clr_we_i ? wdata_i : '0;

  // set beats clear when both land on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_mask) | rise;
    end
  end

  assign pend_o = pend_q;
  assign hit_o  = pend_q & en_o;

  if (IS_NMI) begin : g_nmi
    logic unused_we;
    assign unused_we = lvl_we_i ^ en_we_i;
    assign en_o  = NMI_LIVE;
    assign lvl_o = '0;

    p_rsvd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[FACT_N-1] |=> !pend_o[FACT_N-1]);
  end else begin : g_mask
    logic [FACT_N-1:0] en_q;
    logic [LVL_W-1:0]  lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= '0;
        lvl_q <= LVL_MAX;
      end else begin
        if (en_we_i) en_q <= wdata_i;
        if (lvl_we_i && (wdata_i[LVL_W-1:0] <= LVL_MAX)) lvl_q <= wdata_i[LVL_W-1:0];
      end
    end
    assign en_o  = en_q;
    assign lvl_o = lvl_q;

    p_lvl_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_o <= LVL_MAX);
    p_bad_lvl_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_we_i && wdata_i[LVL_W-1:0] > LVL_MAX) |=> $stable(lvl_o));
  end

  for (genvar f = 0; f < FACT_N; f++) begin : g_fact
    if (LIVE[f]) begin : g_live
      p_rise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_i[f]) |=> pend_o[f]);
      p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && wdata_i[f] && !(req_i[f] && !req_q[f])) |=> !pend_o[f]);
    end
  end
endmodule

// File: rtl/irq_lvl_merge.sv
module irq_lvl_merge
  import irq_grp_pkg::*;
#(
  parameter int GRP_N = 19
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [GRP_N-1:0]       hit_any_i,
  input  logic [GRP_N*LVL_W-1:0] lvl_i,
  output logic                   nmi_o,
  output logic [LVL_N-1:0]       lvl_req_o
);
  logic unused_lvl0;
  assign unused_lvl0 = ^lvl_i[LVL_W-1:0];

  assign nmi_o = hit_any_i[0];

  always_comb begin
    lvl_req_o = '0;
    for (int g = 1; g < GRP_N; g++) begin
      for (int l = 0; l < LVL_N; l++) begin
        if (hit_any_i[g] && (lvl_i[g*LVL_W +: LVL_W] == LVL_W'(l))) lvl_req_o[l] = 1'b1;
      end
    end
  end

  p_lvl_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl_req_o) |-> (|hit_any_i[GRP_N-1:1]));
  p_nmi_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_any_i[0]) |-> !nmi_o);
endmodule

// File: rtl/irq_id_arb.sv
module irq_id_arb
  import irq_grp_pkg::*;
#(
  parameter int GRP_N = 19,
  parameter int GRP_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [GRP_N*FACT_N-1:0] hit_i,
  input  logic [GRP_N*LVL_W-1:0]  lvl_i,
  output logic                    id_valid_o,
  output logic [GRP_W-1:0]        id_grp_o,
  output logic [FACT_N-1:0]       id_mask_o
);
  logic [LVL_W:0] best, rank;

  // rank 0 is the NMI group, maskable level L ranks L+1; strict compare keeps lowest group on ties
  always_comb begin
    id_valid_o = 1'b0;
    id_grp_o   = '0;
    id_mask_o  = '0;
    best       = '1;
    rank       = '0;
    for (int g = 0; g < GRP_N; g++) begin
      rank = (g == 0) ? '0 : ({1'b0, lvl_i[g*LVL_W +: LVL_W]} + 1'b1);
      if ((|hit_i[g*FACT_N +: FACT_N]) && (rank < best)) begin
        best       = rank;
        id_valid_o = 1'b1;
        id_grp_o   = GRP_W'(g);
        id_mask_o  = hit_i[g*FACT_N +: FACT_N];
      end
    end
  end

  p_id_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> (id_grp_o < GRP_W'(GRP_N)));
  p_id_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i == '0) |-> !id_valid_o);
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import irq_grp_pkg::*;
#(
  parameter int GRP_N  = 19,
  parameter int GRP_W  = $clog2(GRP_N),
  parameter int ADDR_W = GRP_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [GRP_N*FACT_N-1:0] req_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    nmi_o,
  output logic [LVL_N-1:0]        lvl_req_o
);
  logic [GRP_W-1:0]          a_grp;
  reg_sel_e                  a_sel;
  logic                      a_ok;
  logic [GRP_N*LVL_W-1:0]    lvl_all;
  logic [GRP_N*FACT_N-1:0]   en_all, pend_all, hit_all;
  logic [GRP_N-1:0]          hit_any;
  logic                      id_valid;
  logic [GRP_W-1:0]          id_grp;
  logic [FACT_N-1:0]         id_mask;
  logic                      unused_wdata;

  assign a_grp = addr_i[ADDR_W-1:2];
  assign a_sel = reg_sel_e'(addr_i[1:0]);
  assign a_ok  = (a_grp < GRP_W'(GRP_N));
  assign unused_wdata = ^wdata_i[DATA_W-1:FACT_N];

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic sel_g;
    assign sel_g = wr_en_i && a_ok && (a_grp == GRP_W'(g));
    irq_grp_bank #(.IS_NMI(g == 0)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[g*FACT_N +: FACT_N]),
      .lvl_we_i (sel_g && (a_sel == SEL_LVL)),
      .en_we_i  (sel_g && (a_sel == SEL_EN)),
      .clr_we_i (sel_g && (a_sel == SEL_PEND)),
      .wdata_i  (wdata_i[FACT_N-1:0]),
      .lvl_o    (lvl_all[g*LVL_W +: LVL_W]),
      .en_o     (en_all[g*FACT_N +: FACT_N]),
      .pend_o   (pend_all[g*FACT_N +: FACT_N]),
      .hit_o    (hit_all[g*FACT_N +: FACT_N])
    );
    assign hit_any[g] = |hit_all[g*FACT_N +: FACT_N];
  end

  irq_lvl_merge #(.GRP_N(GRP_N)) u_merge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_any_i (hit_any),
    .lvl_i     (lvl_all),
    .nmi_o     (nmi_o),
    .lvl_req_o (lvl_req_o)
  );

  irq_id_arb #(.GRP_N(GRP_N), .GRP_W(GRP_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit_all),
    .lvl_i      (lvl_all),
    .id_valid_o (id_valid),
    .id_grp_o   (id_grp),
    .id_mask_o  (id_mask)
  );

  always_comb begin
    rdata_o = '0;
    if (a_ok) begin
      for (int g = 0; g < GRP_N; g++) begin
        if (a_grp == GRP_W'(g)) begin
          unique case (a_sel)
            SEL_LVL:  rdata_o[LVL_W-1:0]  = lvl_all[g*LVL_W +: LVL_W];
            SEL_EN:   rdata_o[FACT_N-1:0] = en_all[g*FACT_N +: FACT_N];
            SEL_PEND: rdata_o[FACT_N-1:0] = pend_all[g*FACT_N +: FACT_N];
            SEL_ID: begin
              rdata_o[DATA_W-1]      = id_valid;
              rdata_o[8 +: GRP_W]    = id_grp;
              rdata_o[FACT_N-1:0]    = id_mask;
            end
          endcase
        end
      end
    end
  end

  p_nmi_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (id_valid && id_grp == '0));
  p_quiet_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_o && lvl_req_o == '0) |-> !id_valid);
  p_lvl_has_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_req_o != '0) |-> id_valid);
endmodule

// File: tb/grp_irq_ctrl_bench.sv
module grp_irq_ctrl_bench;
  localparam int G = 19;
  localparam int F = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [G*F-1:0] req = '0;
  logic          we = 1'b0;
  logic [6:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          nmi;
  logic [6:0]    lvl_req;

  int n_cmp = 0;
  int n_bad = 0;
  int          m_lvl  [G];
  logic [3:0]  m_en   [G];
  logic [3:0]  m_pend [G];

  always #4 clk = ~clk;

  grp_irq_ctrl u_grp_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .nmi_o(nmi), .lvl_req_o(lvl_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic rd(input int g, input int sel, output logic [15:0] d);
    @(negedge clk);
    addr = 7'((g << 2) | sel);
    #1 d = rdata;
  endtask

  task automatic wr(input int g, input int sel, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = 7'((g << 2) | sel); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [15:0] exp_id();
    int best = 99;
    logic [15:0] w = '0;
    for (int g = 0; g < G; g++) begin
      int r = (g == 0) ? 0 : m_lvl[g] + 1;
      if ((m_pend[g] & m_en[g]) != 0 && r < best) begin
        best = r;
        w = 16'h8000 | 16'(g << 8) | 16'(m_pend[g] & m_en[g]);
      end
    end
    return w;
  endfunction

  task automatic check_out(input string tag);
    logic [6:0] el = '0;
    logic [15:0] d;
    for (int g = 1; g < G; g++) if ((m_pend[g] & m_en[g]) != 0) el[m_lvl[g]] = 1'b1;
    chk({tag, " R6 nmi"}, 32'(nmi), 32'(|(m_pend[0] & m_en[0])));
    chk({tag, " R4 lvl"}, 32'(lvl_req), 32'(el));
    rd(0, 3, d);
    chk({tag, " R10 id"}, 32'(d), 32'(exp_id()));
  endtask

  task automatic check_regs(input string tag);
    logic [15:0] d;
    for (int g = 0; g < G; g++) begin
      rd(g, 0, d); chk({tag, " lvl reg"}, 32'(d), 32'(m_lvl[g]));
      rd(g, 1, d); chk({tag, " en reg"}, 32'(d), 32'(m_en[g]));
      rd(g, 2, d); chk({tag, " pend reg"}, 32'(d), 32'(m_pend[g]));
    end
  endtask

  // raise one request bit; pending latches at the edge between the two falling edges
  task automatic rise(input int g, input int f);
    @(negedge clk);
    req[g*F+f] = 1'b1;
    @(negedge clk);
    if (!(g == 0 && f == 3)) m_pend[g][f] = 1'b1;
  endtask

  task automatic fall(input int g, input int f);
    @(negedge clk);
    req[g*F+f] = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr(input int g, input logic [3:0] m);
    wr(g, 2, 16'(m));
    m_pend[g] = m_pend[g] & ~m;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] d;
    for (int g = 0; g < G; g++) begin
      m_lvl[g] = (g == 0) ? 0 : 6;
      m_en[g]  = (g == 0) ? 4'b0111 : 4'b0000;
      m_pend[g] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_regs("R1 reset");
    check_out("R1 reset");

    // program levels g%7, enable all; R9 level 7 ignored
    for (int g = 1; g < G; g++) begin
      wr(g, 0, 16'(g % 7)); m_lvl[g] = g % 7;
      wr(g, 1, 16'hF);      m_en[g] = 4'hF;
    end
    wr(5, 0, 16'd7);
    rd(5, 0, d); chk("R9 level 7 ignored", 32'(d), 32'd5);
    // R6, R7 group 0 writes ignored
    wr(0, 0, 16'd3);
    wr(0, 1, 16'h0);
    rd(0, 0, d); chk("R6 grp0 level", 32'(d), 32'd0);
    rd(0, 1, d); chk("R7 grp0 enable", 32'(d), 32'h7);
    check_regs("R9 programmed");

    // R2 R4 R10 R8 sweep every factor alone
    for (int g = 0; g < G; g++) begin
      for (int f = 0; f < F; f++) begin
        rise(g, f);
        check_out("R2 sweep");
        rd(g, 2, d); chk("R2 R8 pend", 32'(d), 32'(m_pend[g]));
        clr(g, 4'(1 << f));
        rd(g, 2, d); chk("R3 cleared", 32'(d), 32'(m_pend[g]));
        @(negedge clk);
        rd(g, 2, d); chk("R2 held no reset", 32'(d), 32'd0);
        fall(g, f);
      end
    end

    // R10 tie: groups 1 and 8 both level 1, then level 0 group 14, then nmi
    rise(8, 2); rise(1, 1);
    check_out("R10 tie");
    rise(14, 0);
    check_out("R10 lower level");
    rise(0, 1);
    check_out("R10 nmi first");
    rise(0, 3);
    rd(0, 2, d); chk("R8 reserved", 32'(d), 32'h2);
    clr(0, 4'hF); clr(14, 4'hF);
    check_out("R10 after clear");
    // R3 write zero no effect
    wr(1, 2, 16'h0);
    rd(1, 2, d); chk("R3 write zero", 32'(d), 32'(m_pend[1]));
    clr(1, 4'hF); clr(8, 4'hF);
    for (int i = 0; i < G * F; i++) req[i] = 1'b0;
    repeat (2) @(negedge clk);
    check_out("R3 idle");

    // R3 set beats clear on same edge
    @(negedge clk);
    req[6*F+0] = 1'b1;
    we = 1'b1; addr = 7'((6 << 2) | 2); wdata = 16'h1;
    @(negedge clk);
    we = 1'b0;
    m_pend[6][0] = 1'b1;
    rd(6, 2, d); chk("R3 set wins", 32'(d), 32'h1);
    check_out("R3 set wins");
    clr(6, 4'h1);
    fall(6, 0);

    // R5 disabled factor latches but stays silent
    wr(3, 1, 16'b1011); m_en[3] = 4'b1011;
    rise(3, 2);
    rd(3, 2, d); chk("R5 pend recorded", 32'(d), 32'h4);
    check_out("R5 silent");
    wr(3, 1, 16'hF); m_en[3] = 4'hF;
    check_out("R5 re-enabled");
    clr(3, 4'hF);
    fall(3, 2);
    check_regs("R5 final");

    report();
  end
endmodule